// File: doc/BRIEF.md
# DDR3 Clock-Enable Power-State Checker

This block is a passive observer that sits beside the command bus between a memory controller and a DDR3 device. On every rising clock edge it samples the clock-enable line, the four active-low command strobes, the bank address and address bit 10. From these samples it follows the power state the device must be in: idle, active, active power down, precharge power down or self refresh. It drives nothing onto the bus.

The next state is decided from three things. These are the clock-enable level at the previous edge and at the current edge, the command registered at the current edge, and whether any bank is open. The checker reports any edge where the clock enable or the command breaks the power-mode rules. Every minimum window is an instance parameter counted in clock cycles. Reports appear as a one-cycle violation pulse and as a sticky error code that only reset clears.

Top module: `cke_pstate_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `state_o` is 0 (idle), `viol_o` is 0 and `err_code_o` is 0.
- R2: Commands decode from {cs_n,ras_n,cas_n,we_n}. 1xxx is deselect, 0111 is NOP, 0011 is activate, 0101 is read, 0100 is write, 0010 is precharge (all banks when `a10`=1), 0001 is refresh and 0000 is mode-register set. On an edge with the clock enable high at both that edge and the one before, activate opens bank `ba`, precharge closes it, and all-bank precharge closes every bank. After such an edge, `state_o` is 1 (active) if a bank is open and 0 (idle) otherwise.
- R3: A high-to-low clock-enable edge that is not a refresh moves the state to 2 (active power down) if a bank is open, or to 3 (precharge power down) if none is open. The state holds while the clock enable stays low. A low-to-high edge returns from 2 to 1 and from 3 to 0.
- R4: A high-to-low edge carrying refresh enters state 4 (self refresh) when no bank is open and no read or write was registered in the last `T_BURST` edges. Otherwise it reports code 3 and takes the power-down state that R3 gives. State 4 holds while the clock enable stays low. A low-to-high edge leaves it for state 0.
- R5: A power-down entry edge whose command is neither NOP, deselect nor refresh reports code 4. Any low-to-high edge whose command is neither NOP nor deselect reports code 5.
- R6: On an edge with the clock enable high on both edges, fewer than `T_XS` edges after a self-refresh exit, any command other than NOP or deselect reports code 6.
- R7: A read fewer than `T_XSDLL` edges after a self-refresh exit reports code 7. A write fewer than `T_WR_SREF` edges after it reports code 8.
- R8: A clock-enable change fewer than `T_CKE` edges after the previous change reports code 1.
- R9: A high-to-low clock-enable edge fewer than max(`T_MRD`,`T_MOD`) edges after a mode-register set reports code 2.
- R10: `viol_o` is high for exactly the cycle after each offending edge. When one edge breaks several rules, the lowest code is the one reported. `err_code_o` takes the first reported code and keeps it until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Sampled clock-enable line |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10, selects all-bank precharge |
| ba | input | BA_W | Bank address |
| state_o | output | 3 | Decoded power state (0 idle, 1 active, 2 active PD, 3 precharge PD, 4 self refresh) |
| viol_o | output | 1 | One-cycle violation pulse |
| err_code_o | output | 4 | Sticky code of the first violation |

## Verification
The bench uses short windows: `T_CKE`=3, `T_MRD`=2, `T_MOD`=5, `T_XS`=6, `T_XSDLL`=14, `T_WR_SREF`=24 and `T_BURST`=4. With these values every window edge, including the write window that lasts 512 cycles at default values, is reached in a few dozen cycles. Random traffic therefore runs into self-refresh exits, early reads and writes, and clock-enable glitches often. Directed runs place commands one edge inside and exactly on each window limit.

// File: rtl/cke_mon_pkg.sv
package cke_mon_pkg;

    typedef enum logic [3:0] {
        CMD_DES, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
        CMD_PRE, CMD_PREA, CMD_REF, CMD_MRS, CMD_OTHER
    } cmd_e;

    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_ACTIVE = 3'd1,
        PS_PD_ACT = 3'd2,
        PS_PD_PRE = 3'd3,
        PS_SREF   = 3'd4
    } pstate_e;

    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_CKE_PULSE = 4'd1,
        ERR_MRS_CKE   = 4'd2,
        ERR_SREF_BUSY = 4'd3,
        ERR_ENTRY_CMD = 4'd4,
        ERR_EXIT_CMD  = 4'd5,
        ERR_XS_CMD    = 4'd6,
        ERR_XS_READ   = 4'd7,
        ERR_XS_WRITE  = 4'd8
    } err_e;

    function automatic logic is_quiet(cmd_e c);
        return (c == CMD_DES) || (c == CMD_NOP);
    endfunction

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
    import cke_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DES;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/cke_bank_track.sv
module cke_bank_track
    import cke_mon_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  cmd_e             cmd,
    input  logic [BA_W-1:0]  ba,
    output logic [NBANK-1:0] open_d,
    output logic [NBANK-1:0] open_q
);
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(i));
        assign open_d[i] = !en                         ? open_q[i] :
                           (cmd == CMD_PREA)           ? 1'b0      :
                           (sel && cmd == CMD_ACT)     ? 1'b1      :
                           (sel && cmd == CMD_PRE)     ? 1'b0      :
                                                         open_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= '0;
        else     open_q <= open_d;
    end
endmodule

// File: rtl/cke_since_cnt.sv
module cke_since_cnt #(
    parameter int LIMIT = 4,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CAP = W'(LIMIT);
    logic [W-1:0] cnt_d;

    always_comb begin
        if (hit)               cnt_d = W'(1);
        else if (cnt_q == CAP) cnt_d = CAP;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CAP;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cke_pstate_monitor.sv
module cke_pstate_monitor
    import cke_mon_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int T_CKE     = 3,
    parameter int T_MRD     = 4,
    parameter int T_MOD     = 12,
    parameter int T_XS      = 16,
    parameter int T_XSDLL   = 512,
    parameter int T_WR_SREF = 512,
    parameter int T_BURST   = 4,
    localparam int BA_W     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            a10,
    input  logic [BA_W-1:0] ba,
    output logic [2:0]      state_o,
    output logic            viol_o,
    output logic [3:0]      err_code_o
);
    localparam int GAP     = (T_MRD > T_MOD) ? T_MRD : T_MOD;
    localparam int XS_A    = (T_XS > T_XSDLL) ? T_XS : T_XSDLL;
    localparam int XS_LIM  = (XS_A > T_WR_SREF) ? XS_A : T_WR_SREF;
    localparam int CKE_W   = $clog2(T_CKE + 1);
    localparam int MRS_W   = $clog2(GAP + 1);
    localparam int XS_W    = $clog2(XS_LIM + 1);
    localparam int BURST_W = $clog2(T_BURST + 1);

    localparam logic [CKE_W-1:0]   LIM_CKE  = CKE_W'(T_CKE);
    localparam logic [MRS_W-1:0]   LIM_MRS  = MRS_W'(GAP);
    localparam logic [XS_W-1:0]    LIM_XS   = XS_W'(T_XS);
    localparam logic [XS_W-1:0]    LIM_DLL  = XS_W'(T_XSDLL);
    localparam logic [XS_W-1:0]    LIM_WR   = XS_W'(T_WR_SREF);
    localparam logic [BURST_W-1:0] BURST_LD = BURST_W'(T_BURST);

    typedef struct packed {
        pstate_e            st;
        logic               cke_prev;
        logic               viol;
        err_e               err;
        logic [BURST_W-1:0] burst;
    } regs_t;

    regs_t r_d, r_q;

    cmd_e             cmd;
    logic             hh, hl, lh, quiet, busy;
    logic [NBANK-1:0] open_d, open_q;
    logic [CKE_W-1:0] cke_cnt;
    logic [MRS_W-1:0] mrs_cnt;
    logic [XS_W-1:0]  xs_cnt;
    logic [8:1]       flag;
    err_e             code;

    cke_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10  (a10),  .cmd  (cmd)
    );

    cke_bank_track #(.NBANK(NBANK), .BA_W(BA_W)) u_banks (
        .clk(clk), .rst(rst), .en(hh), .cmd(cmd), .ba(ba),
        .open_d(open_d), .open_q(open_q)
    );

    cke_since_cnt #(.LIMIT(T_CKE), .W(CKE_W)) u_cke_cnt (
        .clk(clk), .rst(rst), .hit(hl | lh), .cnt_q(cke_cnt)
    );

    cke_since_cnt #(.LIMIT(GAP), .W(MRS_W)) u_mrs_cnt (
        .clk(clk), .rst(rst), .hit(hh && cmd == CMD_MRS), .cnt_q(mrs_cnt)
    );

    cke_since_cnt #(.LIMIT(XS_LIM), .W(XS_W)) u_xs_cnt (
        .clk(clk), .rst(rst), .hit(lh && r_q.st == PS_SREF), .cnt_q(xs_cnt)
    );

    always_comb begin
        hh    = r_q.cke_prev & cke;
        hl    = r_q.cke_prev & ~cke;
        lh    = ~r_q.cke_prev & cke;
        quiet = is_quiet(cmd);
        busy  = (|open_q) || (r_q.burst != '0);

        flag[1] = (hl | lh) && (cke_cnt < LIM_CKE);
        flag[2] = hl && (mrs_cnt < LIM_MRS);
        flag[3] = hl && (cmd == CMD_REF) && busy;
        flag[4] = hl && !quiet && (cmd != CMD_REF);
        flag[5] = lh && !quiet;
        flag[6] = hh && !quiet && (xs_cnt < LIM_XS);
        flag[7] = hh && (cmd == CMD_RD) && (xs_cnt < LIM_DLL);
        flag[8] = hh && (cmd == CMD_WR) && (xs_cnt < LIM_WR);

        if      (flag[1]) code = ERR_CKE_PULSE;
        else if (flag[2]) code = ERR_MRS_CKE;
        else if (flag[3]) code = ERR_SREF_BUSY;
        else if (flag[4]) code = ERR_ENTRY_CMD;
        else if (flag[5]) code = ERR_EXIT_CMD;
        else if (flag[6]) code = ERR_XS_CMD;
        else if (flag[7]) code = ERR_XS_READ;
        else if (flag[8]) code = ERR_XS_WRITE;
        else              code = ERR_NONE;

        r_d          = r_q;
        r_d.cke_prev = cke;
        r_d.viol     = (code != ERR_NONE);
        if (r_q.err == ERR_NONE) r_d.err = code;

        if (hh && (cmd == CMD_RD || cmd == CMD_WR)) r_d.burst = BURST_LD;
        else if (r_q.burst != '0)                  r_d.burst = r_q.burst - 1'b1;

        if (hl) begin
            if (cmd == CMD_REF && !busy) r_d.st = PS_SREF;
            else if (|open_q)            r_d.st = PS_PD_ACT;
            else                         r_d.st = PS_PD_PRE;
        end else if (lh) begin
            r_d.st = (r_q.st == PS_PD_ACT) ? PS_ACTIVE : PS_IDLE;
        end else if (hh) begin
            r_d.st = (|open_d) ? PS_ACTIVE : PS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st       <= PS_IDLE;
            r_q.cke_prev <= 1'b1;
            r_q.viol     <= 1'b0;
            r_q.err      <= ERR_NONE;
            r_q.burst    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.st;
    assign viol_o     = r_q.viol;
    assign err_code_o = r_q.err;
endmodule

// File: rtl/cke_pstate_monitor_chk.sv
module cke_pstate_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [2:0] state_o,
    input logic       viol_o,
    input logic [3:0] err_code_o
);
    logic quiet, in_pd;
    assign quiet = cs_n || (ras_n && cas_n && we_n);
    assign in_pd = (state_o == 3'd2) || (state_o == 3'd3);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == 3'd0 && !viol_o && err_code_o == 4'd0)); // R1

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_pd && !cke) |=> (state_o == $past(state_o))); // R3

    AST_IDLE_TO_PPD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && !cke && quiet) |=> (state_o == 3'd3)); // R3

    AST_SREF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && !cke) |=> (state_o == 3'd4)); // R4

    AST_EXIT_BAD_CMD: assert property (@(posedge clk) disable iff (rst)
        ((in_pd || state_o == 3'd4) && cke && !quiet) |=> viol_o); // R5

    AST_VIOL_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (err_code_o != 4'd0)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_code_o != 4'd0) |=> $stable(err_code_o)); // R10
endmodule

bind cke_pstate_monitor cke_pstate_monitor_chk u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .state_o(state_o), .viol_o(viol_o),
    .err_code_o(err_code_o)
);

// File: tb/cke_pstate_monitor_test.sv
`timescale 1ns/1ps
module cke_pstate_monitor_test;
    localparam int T_CKE = 3, T_MRD = 2, T_MOD = 5, T_XS = 6;
    localparam int T_XSDLL = 14, T_WR_SREF = 24, T_BURST = 4;
    localparam int GAP = (T_MRD > T_MOD) ? T_MRD : T_MOD;
    localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                           P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                           P_REF = 4'b0001, P_MRS = 4'b0000;

    logic clk = 0, rst = 1, cke = 1, cs_n = 0, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
    logic [2:0] ba = 0;
    logic [2:0] state_o;
    logic viol_o;
    logic [3:0] err_code_o;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_st, m_err, m_code, ecount = 0;
    int last_tr, last_mrs, last_sx, last_rw;
    bit m_ckep, m_viol;
    bit [7:0] m_open;

    always #2.5 clk = ~clk;

    cke_pstate_monitor #(
        .NBANK(8), .T_CKE(T_CKE), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_XS(T_XS),
        .T_XSDLL(T_XSDLL), .T_WR_SREF(T_WR_SREF), .T_BURST(T_BURST)
    ) uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
        .state_o(state_o), .viol_o(viol_o), .err_code_o(err_code_o)
    );

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic string stag(input int s);
        if (s == 4) return "R4 state";
        if (s >= 2) return "R3 state";
        return "R2 state";
    endfunction

    function automatic string ctag(input int c);
        case (c)
            1: return "R8 violation";
            2: return "R9 violation";
            3: return "R4 violation";
            4, 5: return "R5 violation";
            6: return "R6 violation";
            7, 8: return "R7 violation";
            default: return "R10 no violation";
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; m_err = 0; m_code = 0; m_viol = 0; m_ckep = 1; m_open = 0;
        last_tr = ecount - 100000; last_mrs = last_tr; last_sx = last_tr; last_rw = last_tr;
    endtask

    task automatic model_edge(input bit c, input logic [3:0] p, input logic [2:0] b, input bit a);
        int code = 0, nst = m_st;
        bit quiet = p[3] || (p[2:0] == 3'b111);
        bit isrd = (p == P_RD), iswr = (p == P_WR), isref = (p == P_REF);
        if (c != m_ckep && ecount - last_tr < T_CKE) code = 1;
        if (m_ckep && !c && ecount - last_mrs < GAP && code == 0) code = 2;
        if (m_ckep && !c) begin
            if (isref && m_open == 0 && ecount - last_rw > T_BURST) nst = 4;
            else begin
                if (isref && code == 0) code = 3;
                if (!isref && !quiet && code == 0) code = 4;
                nst = (m_open != 0) ? 2 : 3;
            end
        end else if (!m_ckep && c) begin
            if (!quiet && code == 0) code = 5;
            if (m_st == 4) begin nst = 0; last_sx = ecount; end
            else nst = (m_st == 2) ? 1 : 0;
        end else if (m_ckep && c) begin
            if (!quiet && ecount - last_sx < T_XS && code == 0) code = 6;
            if (isrd && ecount - last_sx < T_XSDLL && code == 0) code = 7;
            if (iswr && ecount - last_sx < T_WR_SREF && code == 0) code = 8;
            if (p == P_ACT) m_open[b] = 1'b1;
            if (p == P_PRE) begin if (a) m_open = 0; else m_open[b] = 1'b0; end
            if (isrd || iswr) last_rw = ecount;
            if (p == P_MRS) last_mrs = ecount;
            nst = (m_open != 0) ? 1 : 0;
        end
        if (c != m_ckep) last_tr = ecount;
        m_ckep = c; m_st = nst; m_code = code; m_viol = (code != 0);
        if (m_err == 0) m_err = code;
        ecount++;
    endtask

    task automatic step(input bit c, input logic [3:0] p, input logic [2:0] b = 0, input bit a = 0);
        cke = c; {cs_n, ras_n, cas_n, we_n} = p; ba = b; a10 = a;
        model_edge(c, p, b, a);
        @(negedge clk);
        check(int'(state_o), m_st, stag(m_st));
        check(int'(viol_o), int'(m_viol), ctag(m_code));
        check(int'(err_code_o), m_err, "R10 sticky code");
    endtask

    task automatic reset_dut();
        rst = 1; cke = 1; {cs_n, ras_n, cas_n, we_n} = P_NOP;
        repeat (3) @(negedge clk);
        check(int'(state_o), 0, "R1 reset state");
        check(int'(viol_o), 0, "R1 reset viol");
        check(int'(err_code_o), 0, "R1 reset code");
        rst = 0;
        model_reset();
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(1, P_NOP);
    endtask

    task automatic sref_round();
        reset_dut();
        step(0, P_REF);
        check(int'(state_o), 4, "R4 enter self refresh");
        step(0, P_NOP); step(0, P_DES); step(0, P_NOP);
        step(1, P_NOP);
        check(int'(state_o), 0, "R4 exit self refresh");
    endtask

    task automatic rand_step();
        bit c;
        logic [3:0] p;
        int r;
        bit a = $urandom % 2;
        if (m_ckep) c = ($urandom % 100 < 7) ? 1'b0 : 1'b1;
        else        c = ($urandom % 100 < 30) ? 1'b1 : 1'b0;
        r = $urandom % 100;
        if (m_ckep && c) begin
            if      (r < 20) p = P_ACT;
            else if (r < 30) p = P_RD;
            else if (r < 40) p = P_WR;
            else if (r < 60) p = P_PRE;
            else if (r < 65) p = P_REF;
            else if (r < 68) p = P_MRS;
            else if (r < 90) p = P_NOP;
            else             p = P_DES;
            if (p == P_PRE) a = (r >= 55);
        end else if (m_ckep) begin
            p = (r < 35) ? P_REF : (r < 85) ? P_NOP : (r < 95) ? P_DES : P_ACT;
        end else begin
            p = (r < 85) ? P_NOP : (r < 93) ? P_DES : P_RD;
        end
        step(c, p, 3'($urandom % 8), a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_ca11));
        model_reset();

        // R2: bank map drives idle/active
        reset_dut();
        step(1, P_ACT, 3); check(int'(state_o), 1, "R2 active after ACT");
        step(1, P_ACT, 5);
        step(1, P_PRE, 3); check(int'(state_o), 1, "R2 one bank still open");
        step(1, P_PRE, 5); check(int'(state_o), 0, "R2 idle after PRE");
        step(1, P_ACT, 0); step(1, P_ACT, 7);
        step(1, P_PRE, 2, 1); check(int'(state_o), 0, "R2 idle after PREA");

        // R3: active power down round trip
        reset_dut();
        step(1, P_ACT, 2); nops(3);
        step(0, P_NOP); check(int'(state_o), 2, "R3 active power down");
        step(0, P_DES); step(0, P_NOP);
        step(1, P_DES); check(int'(state_o), 1, "R3 back to active");

        // R8: CKE pulse too short, then exactly at the limit
        reset_dut();
        step(0, P_NOP); step(0, P_NOP); step(1, P_NOP);
        check(int'(err_code_o), 1, "R8 short CKE pulse");
        reset_dut();
        step(0, P_NOP); step(0, P_NOP); step(0, P_NOP); step(1, P_NOP);
        check(int'(err_code_o), 0, "R8 CKE pulse at limit");

        // R9: CKE low after MRS
        reset_dut();
        step(1, P_MRS); nops(GAP - 2); step(0, P_NOP);
        check(int'(err_code_o), 2, "R9 CKE low inside MRS gap");
        reset_dut();
        step(1, P_MRS); nops(GAP - 1); step(0, P_NOP);
        check(int'(err_code_o), 0, "R9 CKE low at MRS gap");
        check(int'(state_o), 3, "R3 precharge power down");

        // R4: self-refresh entry when not idle
        reset_dut();
        step(1, P_ACT, 1); nops(3); step(0, P_REF);
        check(int'(err_code_o), 3, "R4 refresh entry with open bank");
        check(int'(state_o), 2, "R4 falls back to power down");
        reset_dut();
        step(1, P_RD); step(1, P_NOP); step(0, P_REF);
        check(int'(err_code_o), 3, "R4 refresh entry during burst");

        // R5: bad commands on entry and exit
        reset_dut();
        step(0, P_ACT, 4);
        check(int'(err_code_o), 4, "R5 entry with ACT");
        reset_dut();
        step(0, P_NOP); step(0, P_NOP); step(0, P_NOP); step(1, P_RD);
        check(int'(err_code_o), 5, "R5 exit with READ");

        // R6/R7: windows after self-refresh exit
        sref_round(); step(1, P_ACT, 0);
        check(int'(err_code_o), 6, "R6 command inside tXS");
        sref_round(); nops(T_XS - 1); step(1, P_RD);
        check(int'(err_code_o), 7, "R7 read before DLL window");
        sref_round(); nops(T_XSDLL - 1); step(1, P_RD);
        check(int'(err_code_o), 0, "R7 read at DLL window");
        sref_round(); nops(T_XSDLL - 1); step(1, P_WR);
        check(int'(err_code_o), 8, "R7 write before write window");
        sref_round(); nops(T_WR_SREF - 1); step(1, P_WR);
        check(int'(err_code_o), 0, "R7 write at write window");

        // R10: priority, pulse width, stickiness
        reset_dut();
        step(0, P_ACT); step(0, P_NOP); step(1, P_RD);
        check(int'(viol_o), 1, "R10 second violation pulses");
        check(int'(err_code_o), 4, "R10 first code kept");
        step(1, P_NOP);
        check(int'(viol_o), 0, "R10 pulse lasts one cycle");

        // random traffic
        reset_dut();
        for (int i = 0; i < 4000; i++) begin
            if (m_err != 0 && $urandom % 10 == 0) reset_dut();
            rand_step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule